// File: doc/BRIEF.md
# Master Data Byte Queue

This block is the small byte store that sits between a host register port and an I2C master engine. On a transmit, the host pushes the bytes to send one at a time. The engine reads the whole store through a parallel view and sends them. On a receive, the engine drops in a group of bytes at once together with their count. The host then pops them one by one, oldest first.

Storage works as a shift queue. The oldest byte always sits in slot 0 and drives the read-data port. Each pop moves the remaining bytes down one slot in the same clock edge.

Two status flags follow the fill level, not-empty and full. They are registers that change only on the fill transitions that cross their thresholds. A flush input empties the store and zeroes it, and so does the synchronous reset.

Top module: `xfer_byte_buf`

## Requirements
- R1: After a synchronous reset the fill level is 0, both flags are low and every byte of the parallel view is zero.
- R2: A host write that finds room stores the byte in the first free slot and raises the fill level by one. The not-empty flag goes high when the first byte enters.
- R3: The read-data port always shows slot 0. A host read of a non-empty queue removes slot 0 and shifts every later byte down one slot at the same edge. The vacated top slot becomes zero.
- R4: While the queue is empty, the read-data port shows 0xFF, and a host read changes neither the level, the flags nor the contents.
- R5: A host write while four bytes are held, with no read in the same cycle, is dropped. Level and contents stay unchanged and the level never exceeds four.
- R6: The full flag goes high when the fourth byte enters. It goes low when a read takes a byte from a full queue without a write in the same cycle.
- R7: The not-empty flag goes low when a read removes the last byte, unless a write arrives in the same cycle.
- R8: A flush empties the queue, zeroes all slots and lowers both flags. It overrides every other input in that cycle.
- R9: An engine group load places slot i at eng_data bits [8i+7:8i] and sets the level to eng_count. A count above four is treated as four. The flags are derived from the new level, and the load overrides host reads and writes in that cycle.
- R10: A host read and write in the same cycle pop first and then push. At full the level stays four and the full flag stays high. At empty the written byte is stored and 0xFF is shown during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host pushes host_wdata this cycle |
| host_wdata | input | 8 | Byte to push |
| host_rd | input | 1 | Host pops slot 0 this cycle |
| host_rdata | output | 8 | Slot 0, or 0xFF when empty |
| flush | input | 1 | Empty and zero the queue |
| eng_load | input | 1 | Engine group load strobe |
| eng_count | input | 3 | Number of valid bytes in the load |
| eng_data | input | 32 | Bytes of the load, slot i at bits [8i+7:8i] |
| buf_view | output | 32 | Parallel view of all slots, same packing |
| fill_level | output | 3 | Number of bytes held |
| flag_nonempty | output | 1 | Queue holds at least one byte |
| flag_full | output | 1 | Queue holds four bytes |

## Verification
The assertions assume that flush, eng_load, host_rd and host_wr are clean levels sampled once per edge. They also assume eng_count is meaningful only with eng_load, and that no input goes unknown after reset. The relation between each flag and the level is assumed only while reset is low. The bench drives every input at the falling edge from its own tasks. Flush and load appear only occasionally, so that long push and pop runs reach both the full and the empty boundary. Load counts are drawn across the whole 0 to 7 range, so the clamp above four is exercised.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
    localparam int BUF_DEPTH  = 4;
    localparam int BYTE_W     = 8;
    localparam logic [7:0] EMPTY_READ_BYTE = 8'hFF;

    // which source decides the next state this cycle, in priority order
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_FLUSH = 2'd1,
        SRC_LOAD  = 2'd2,
        SRC_HOST  = 2'd3
    } buf_src_e;

    typedef struct packed {
        logic push;
        logic pop;
    } host_op_t;

    function automatic buf_src_e pick_source(input logic fl, input logic ld,
                                             input logic wr, input logic rd);
        if (fl)            return SRC_FLUSH;
        else if (ld)       return SRC_LOAD;
        else if (wr || rd) return SRC_HOST;
        else               return SRC_IDLE;
    endfunction
endpackage

// File: rtl/xbb_ctrl.sv
module xbb_ctrl
    import xbb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          flush,
    input  logic          eng_load,
    input  logic [LW-1:0] eng_count,
    output logic [LW-1:0] level,
    output host_op_t      op,
    output logic [LW-1:0] wr_slot,
    output logic [LW-1:0] load_level,
    output buf_src_e      src
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] ONE      = LW'(1);

    logic [LW-1:0] level_nxt;

    always_comb begin
        src        = pick_source(flush, eng_load, host_wr, host_rd);
        op.pop     = (src == SRC_HOST) && host_rd && (level != '0);
        op.push    = (src == SRC_HOST) && host_wr && ((level != FULL_LVL) || op.pop);
        wr_slot    = op.pop ? level - ONE : level;
        load_level = (eng_count > FULL_LVL) ? FULL_LVL : eng_count;
        level_nxt  = level;
        case (src)
            SRC_FLUSH: level_nxt = '0;
            SRC_LOAD:  level_nxt = load_level;
            SRC_HOST: begin
                if (op.pop && !op.push)      level_nxt = level - ONE;
                else if (op.push && !op.pop) level_nxt = level + ONE;
            end
            default:   level_nxt = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) level <= '0;
        else     level <= level_nxt;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R4
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && !flush && !eng_load && level == '0) |=> level == '0);

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && !flush && !eng_load && level == FULL_LVL) |=> level == FULL_LVL);

    // R9
    load_level_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_load && !flush && eng_count <= FULL_LVL) |=> level == $past(eng_count));

    // R8
    flush_level_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> level == '0);
endmodule

// File: rtl/xbb_store.sv
module xbb_store
    import xbb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int BW    = BYTE_W,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  buf_src_e            src,
    input  host_op_t            op,
    input  logic [LW-1:0]       wr_slot,
    input  logic [BW-1:0]       wdata,
    input  logic [DEPTH*BW-1:0] load_data,
    output logic [DEPTH*BW-1:0] view
);
    logic [BW-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [LW-1:0] SLOT_IDX = LW'(i);
        logic [BW-1:0] above;
        logic [BW-1:0] kept;

        if (i == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = slot_q[i+1];
        end

        assign kept = op.pop ? above : slot_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else begin
                case (src)
                    SRC_FLUSH: slot_q[i] <= '0;
                    SRC_LOAD:  slot_q[i] <= load_data[i*BW +: BW];
                    SRC_HOST:  slot_q[i] <= (op.push && wr_slot == SLOT_IDX) ? wdata : kept;
                    default:   slot_q[i] <= slot_q[i];
                endcase
            end
        end

        assign view[i*BW +: BW] = slot_q[i];
    end

    // R8
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_FLUSH) |=> view == '0);

    // R3
    pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_HOST && op.pop && !op.push) |=>
            view[BW-1:0] == $past(view[2*BW-1:BW]));
endmodule

// File: rtl/xbb_flags.sv
module xbb_flags
    import xbb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  buf_src_e      src,
    input  host_op_t      op,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] load_level,
    output logic          nonempty,
    output logic          full
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] ONE      = LW'(1);

    logic first_in, last_out, fourth_in, leave_full;

    always_comb begin
        first_in   = op.push && !op.pop && (level == '0);
        last_out   = op.pop && !op.push && (level == ONE);
        fourth_in  = op.push && !op.pop && (level == FULL_LVL - ONE);
        leave_full = op.pop && !op.push && (level == FULL_LVL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nonempty <= 1'b0;
            full     <= 1'b0;
        end else begin
            case (src)
                SRC_FLUSH: begin
                    nonempty <= 1'b0;
                    full     <= 1'b0;
                end
                SRC_LOAD: begin
                    nonempty <= (load_level != '0);
                    full     <= (load_level == FULL_LVL);
                end
                SRC_HOST: begin
                    if (first_in)        nonempty <= 1'b1;
                    else if (last_out)   nonempty <= 1'b0;
                    if (fourth_in)       full <= 1'b1;
                    else if (leave_full) full <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R7
    nonempty_match_chk: assert property (@(posedge clk) disable iff (rst)
        nonempty == (level != '0));

    // R6
    full_match_chk: assert property (@(posedge clk) disable iff (rst)
        full == (level == FULL_LVL));
endmodule

// File: rtl/xfer_byte_buf.sv
module xfer_byte_buf
    import xbb_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int BW    = BYTE_W,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [BW-1:0]       host_wdata,
    input  logic                host_rd,
    output logic [BW-1:0]       host_rdata,
    input  logic                flush,
    input  logic                eng_load,
    input  logic [LW-1:0]       eng_count,
    input  logic [DEPTH*BW-1:0] eng_data,
    output logic [DEPTH*BW-1:0] buf_view,
    output logic [LW-1:0]       fill_level,
    output logic                flag_nonempty,
    output logic                flag_full
);
    host_op_t      op;
    buf_src_e      src;
    logic [LW-1:0] wr_slot;
    logic [LW-1:0] load_level;

    xbb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .flush      (flush),
        .eng_load   (eng_load),
        .eng_count  (eng_count),
        .level      (fill_level),
        .op         (op),
        .wr_slot    (wr_slot),
        .load_level (load_level),
        .src        (src)
    );

    xbb_store #(.DEPTH(DEPTH), .BW(BW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .op        (op),
        .wr_slot   (wr_slot),
        .wdata     (host_wdata),
        .load_data (eng_data),
        .view      (buf_view)
    );

    xbb_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .op         (op),
        .level      (fill_level),
        .load_level (load_level),
        .nonempty   (flag_nonempty),
        .full       (flag_full)
    );

    assign host_rdata = (fill_level == '0) ? BW'(EMPTY_READ_BYTE) : buf_view[BW-1:0];

    // R4
    empty_read_value_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_nonempty |-> host_rdata == BW'(EMPTY_READ_BYTE));
endmodule

// File: tb/xfer_byte_buf_bench.sv
module xfer_byte_buf_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, host_rd, flush, eng_load;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic [2:0]  eng_count;
    logic [31:0] eng_data;
    logic [31:0] buf_view;
    logic [2:0]  fill_level;
    logic        flag_nonempty, flag_full;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] m_q [4];
    int         m_lvl;

    always #10 clk = ~clk;

    xfer_byte_buf u_xfer_byte_buf (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .flush(flush),
        .eng_load(eng_load), .eng_count(eng_count), .eng_data(eng_data),
        .buf_view(buf_view), .fill_level(fill_level),
        .flag_nonempty(flag_nonempty), .flag_full(flag_full)
    );

    function automatic logic [7:0] exp_rdata();
        return (m_lvl == 0) ? 8'hFF : m_q[0];
    endfunction

    function automatic logic [31:0] exp_view();
        return {m_q[3], m_q[2], m_q[1], m_q[0]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic [7:0] wd, input logic rd,
                              input logic fl, input logic ld, input logic [2:0] cnt,
                              input logic [31:0] dat);
        if (fl) begin
            for (int i = 0; i < 4; i++) m_q[i] = 8'h00;
            m_lvl = 0;
        end else if (ld) begin
            for (int i = 0; i < 4; i++) m_q[i] = dat[i*8 +: 8];
            m_lvl = (cnt > 3'd4) ? 4 : int'(cnt);
        end else begin
            if (rd && m_lvl > 0) begin
                for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
                m_q[3] = 8'h00;
                m_lvl--;
            end
            if (wr && m_lvl < 4) begin
                m_q[m_lvl] = wd;
                m_lvl++;
            end
        end
    endtask

    task automatic check_state(input string tag);
        check(tag, "level", 32'(fill_level), 32'(m_lvl));
        check(tag, "nonempty", 32'(flag_nonempty), 32'(m_lvl != 0));
        check(tag, "full", 32'(flag_full), 32'(m_lvl == 4));
        check(tag, "view", buf_view, exp_view());
    endtask

    // called just after a falling edge; returns just after the next falling edge
    task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                        input logic fl, input logic ld, input logic [2:0] cnt,
                        input logic [31:0] dat, input string tag);
        host_wr = wr; host_wdata = wd; host_rd = rd;
        flush = fl; eng_load = ld; eng_count = cnt; eng_data = dat;
        #1;
        check(tag, "rdata", 32'(host_rdata), 32'(exp_rdata()));
        @(posedge clk);
        model_step(wr, wd, rd, fl, ld, cnt, dat);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; flush = 1'b0; eng_load = 1'b0;
        #1;
        check_state(tag);
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL R1 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        host_wr = 0; host_rd = 0; flush = 0; eng_load = 0;
        host_wdata = 0; eng_count = 0; eng_data = 0;
        for (int i = 0; i < 4; i++) m_q[i] = 8'h00;
        m_lvl = 0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_state("R1");
        check("R1", "rdata", 32'(host_rdata), 32'hFF);

        // R4: read while empty
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R4");
        // R2: fill one to four, R6 full at fourth
        step(1, 8'h11, 0, 0, 0, 3'd0, 32'h0, "R2");
        step(1, 8'h22, 0, 0, 0, 3'd0, 32'h0, "R2");
        step(1, 8'h33, 0, 0, 0, 3'd0, 32'h0, "R2");
        step(1, 8'h44, 0, 0, 0, 3'd0, 32'h0, "R6");
        // R5: write while full dropped
        step(1, 8'h55, 0, 0, 0, 3'd0, 32'h0, "R5");
        // R10: read and write while full
        step(1, 8'h66, 1, 0, 0, 3'd0, 32'h0, "R10");
        // R6: read from full clears full; R3 shift
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R6");
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R3");
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R3");
        // R7: last byte out
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R7");
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R4");
        // R10: read and write while empty
        step(1, 8'h77, 1, 0, 0, 3'd0, 32'h0, "R10");
        // R9: group loads with several counts, including clamp
        step(1, 8'h99, 1, 0, 1, 3'd2, 32'hA4A3A2A1, "R9");
        step(0, 8'h00, 0, 0, 1, 3'd4, 32'hB4B3B2B1, "R9");
        step(0, 8'h00, 0, 0, 1, 3'd7, 32'hC4C3C2C1, "R9");
        step(0, 8'h00, 0, 0, 1, 3'd0, 32'hD4D3D2D1, "R9");
        step(0, 8'h00, 1, 0, 0, 3'd0, 32'h0, "R4");
        // R8: flush overrides load and host ops
        step(1, 8'h12, 0, 0, 0, 3'd0, 32'h0, "R2");
        step(1, 8'h34, 1, 1, 1, 3'd3, 32'hE4E3E2E1, "R8");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[15:8], r[2] & r[3] | r[4] & r[0],
                 (r[19:16] == 4'h0), (r[23:20] == 4'h0), r[26:24],
                 $urandom, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule